// File: doc/BRIEF.md
# Tile-Status Fast-Clear Tracker

This block lets a render surface be cleared without touching pixel memory. The surface is split into tiles, and the block holds one "cleared" flag per tile. A fast-clear command raises every flag and stores a clear value. A pixel read from a tile that is still flagged returns that stored value and makes no memory access. A pixel write to a flagged tile drops the flag. The block then fills the rest of that tile with the clear value, so that memory holds a complete tile again.

A fill pass paints every tile that rendering never touched. It walks the tiles in ascending order, writes the fill colour over each pixel of a tile that is still flagged, and drops that tile's flag. Tiles that rendering touched are left alone. When the pass is over, the block raises a one-cycle done pulse.

A single sequencer has five states and drives the single memory write port:

- `ST_IDLE` accepts commands.
- `ST_EXPAND` completes a partially written tile.
- `ST_SCAN` tests the flag of the current tile.
- `ST_FILL` writes one tile with the fill colour.
- `ST_DONE` raises the done pulse.

The transitions are:

- idle→expand on a write to a flagged tile.
- expand→idle after the last pixel offset.
- idle→scan on a fill start.
- scan→fill when the current tile is flagged.
- scan→scan onto the next tile when it is not.
- fill→scan onto the next tile after the last offset.
- scan→done or fill→done at the last tile.
- done→idle unconditionally.

Top module: `tile_clear_tracker`

## Requirements
- R1: After reset no tile is flagged, the stored clear value is 0, `clr_ready` is 1, and `fill_busy` and `fill_done` are 0.
- R2: In `ST_IDLE`, a `clr_cmd` pulse sets every tile's flag and captures `clr_value` at the next clock edge.
- R3: A read is decided within the same cycle, using memory address {tile, offset} (tile in the upper bits). When `ts_en` is 1 and the tile is flagged, `rd_data` equals the clear value and `mem_rd_en` is 0. In every other case `rd_data` equals `mem_rd_data` and `mem_rd_en` is 1.
- R4: In idle, an accepted pixel write to an unflagged tile produces exactly one memory write, in the same cycle, of `px_data` to {tile, offset}. `px_ready` stays 1 in the next cycle.
- R5: In idle, an accepted pixel write to a flagged tile does three things. It writes the pixel in the same cycle and drops the tile's flag. It then spends 2^PIX_LOG2 cycles in `ST_EXPAND`, writing the clear value to every other offset of that tile in ascending order. `px_ready` is 0 during those cycles.
- R6: A fill pass starts on `fill_start` in idle and latches `fill_color`. It visits tiles in ascending index order. For each flagged tile it writes `fill_color` to all offsets and drops the flag. Unflagged tiles are not written.
- R7: `fill_busy` is 1 from the cycle after the start until the last tile has been handled. `fill_done` is then 1 for exactly one cycle, after which the block is idle.
- R8: `clr_ready` is 0 whenever the sequencer is not idle, and a `clr_cmd` given then has no effect.
- R9: In idle, `clr_cmd` takes priority over `fill_start`, which takes priority over `px_we`. `px_ready` is 1 only in idle with neither `clr_cmd` nor `fill_start` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_en | input | 1 | Read path consults tile flags when 1 |
| clr_cmd | input | 1 | Fast-clear command |
| clr_value | input | DW | Clear value captured by the command |
| clr_ready | output | 1 | Sequencer idle, fast clear accepted |
| px_we | input | 1 | Pixel write request |
| px_tile | input | TILE_LOG2 | Pixel write tile index |
| px_off | input | PIX_LOG2 | Pixel offset within tile |
| px_data | input | DW | Pixel write data |
| px_ready | output | 1 | Pixel write accepted this cycle |
| fill_start | input | 1 | Start a fill pass |
| fill_color | input | DW | Background colour for the fill pass |
| fill_busy | output | 1 | Fill pass walking tiles |
| fill_done | output | 1 | One-cycle pulse at end of fill pass |
| rd_en | input | 1 | Pixel read request |
| rd_tile | input | TILE_LOG2 | Read tile index |
| rd_off | input | PIX_LOG2 | Read offset within tile |
| rd_data | output | DW | Read result |
| mem_rd_en | output | 1 | Memory read needed |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The hardest case is a fast clear that arrives during a fill pass. That pass must itself follow a clear and some partial writes, so that only some tiles are still flagged. The stimulus clears the surface and writes into two tiles, one at a middle offset and one at offset 0. It then starts a fill and pulses a second clear with a new value while the walk is running. The reads that follow show the fill colour, not the second clear value, in the untouched tiles. They also show the written tiles unchanged, which confirms both the refusal and the skipping.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPAND,
        ST_SCAN,
        ST_FILL,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/tsc_status.sv
module tsc_status #(
    parameter int TILE_LOG2 = 3,
    parameter int DW        = 16,
    localparam int NT       = 1 << TILE_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_all,
    input  logic [DW-1:0]        new_value,
    input  logic                 clr_one,
    input  logic [TILE_LOG2-1:0] clr_idx,
    output logic [NT-1:0]        flags,
    output logic [DW-1:0]        clear_value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags       <= '0;
            clear_value <= '0;
        end else if (set_all) begin
            flags       <= '1;
            clear_value <= new_value;
        end else if (clr_one) begin
            flags[clr_idx] <= 1'b0;
        end
    end

    // R2
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (&flags));

    // R5
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_one && !set_all) |=> !flags[$past(clr_idx)]);
endmodule

// File: rtl/tsc_rdmux.sv
module tsc_rdmux #(
    parameter int TILE_LOG2 = 3,
    parameter int PIX_LOG2  = 2,
    parameter int DW        = 16,
    localparam int NT       = 1 << TILE_LOG2,
    localparam int AW       = TILE_LOG2 + PIX_LOG2
) (
    input  logic                 rd_en,
    input  logic [TILE_LOG2-1:0] rd_tile,
    input  logic [PIX_LOG2-1:0]  rd_off,
    input  logic                 ts_en,
    input  logic [NT-1:0]        flags,
    input  logic [DW-1:0]        clear_value,
    input  logic [DW-1:0]        mem_rd_data,
    output logic [DW-1:0]        rd_data,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_rd_addr
);
    logic use_clear;

    always_comb begin
        use_clear   = ts_en && flags[rd_tile];
        mem_rd_addr = {rd_tile, rd_off};
        mem_rd_en   = rd_en && !use_clear;
        rd_data     = use_clear ? clear_value : mem_rd_data;
    end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
    import tsc_pkg::*;
#(
    parameter int TILE_LOG2 = 3,
    parameter int PIX_LOG2  = 2,
    parameter int DW        = 16,
    localparam int NT       = 1 << TILE_LOG2,
    localparam int AW       = TILE_LOG2 + PIX_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_cmd,
    input  logic                 px_we,
    input  logic [TILE_LOG2-1:0] px_tile,
    input  logic [PIX_LOG2-1:0]  px_off,
    input  logic [DW-1:0]        px_data,
    input  logic                 fill_start,
    input  logic [DW-1:0]        fill_color,
    input  logic [NT-1:0]        flags,
    input  logic [DW-1:0]        clear_value,
    output logic                 set_all,
    output logic                 clr_one,
    output logic [TILE_LOG2-1:0] clr_idx,
    output logic                 clr_ready,
    output logic                 px_ready,
    output logic                 fill_busy,
    output logic                 fill_done,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata
);
    localparam logic [PIX_LOG2-1:0]  PLAST = '1;
    localparam logic [TILE_LOG2-1:0] TLAST = '1;

    seq_state_t            state_q;
    logic [TILE_LOG2-1:0]  tile_q;
    logic [PIX_LOG2-1:0]   cnt_q;
    logic [PIX_LOG2-1:0]   skip_q;
    logic [DW-1:0]         color_q;

    // state register and walk counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tile_q  <= '0;
            cnt_q   <= '0;
            skip_q  <= '0;
            color_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (clr_cmd) begin
                        state_q <= ST_IDLE;
                    end else if (fill_start) begin
                        state_q <= ST_SCAN;
                        tile_q  <= '0;
                        color_q <= fill_color;
                    end else if (px_we && flags[px_tile]) begin
                        state_q <= ST_EXPAND;
                        tile_q  <= px_tile;
                        skip_q  <= px_off;
                        cnt_q   <= '0;
                    end
                end
                ST_EXPAND: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == PLAST) state_q <= ST_IDLE;
                end
                ST_SCAN: begin
                    if (flags[tile_q]) begin
                        state_q <= ST_FILL;
                        cnt_q   <= '0;
                    end else if (tile_q == TLAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        tile_q <= tile_q + 1'b1;
                    end
                end
                ST_FILL: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == PLAST) begin
                        if (tile_q == TLAST) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_SCAN;
                            tile_q  <= tile_q + 1'b1;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        set_all   = 1'b0;
        clr_one   = 1'b0;
        clr_idx   = tile_q;
        clr_ready = 1'b0;
        px_ready  = 1'b0;
        fill_busy = 1'b0;
        fill_done = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {tile_q, cnt_q};
        mem_wdata = clear_value;
        unique case (state_q)
            ST_IDLE: begin
                clr_ready = 1'b1;
                set_all   = clr_cmd;
                px_ready  = !clr_cmd && !fill_start;
                if (px_ready && px_we) begin
                    mem_we    = 1'b1;
                    mem_addr  = {px_tile, px_off};
                    mem_wdata = px_data;
                    clr_one   = flags[px_tile];
                    clr_idx   = px_tile;
                end
            end
            ST_EXPAND: begin
                mem_we = (cnt_q != skip_q);
            end
            ST_SCAN: begin
                fill_busy = 1'b1;
            end
            ST_FILL: begin
                fill_busy = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = color_q;
                clr_one   = (cnt_q == PLAST);
            end
            ST_DONE: begin
                fill_done = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (clr_ready && !fill_done));

    // R6
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && $past(fill_busy)) |-> (tile_q >= $past(tile_q)));
endmodule

// File: rtl/tile_clear_tracker.sv
module tile_clear_tracker #(
    parameter int TILE_LOG2 = 3,
    parameter int PIX_LOG2  = 2,
    parameter int DW        = 16,
    localparam int NT       = 1 << TILE_LOG2,
    localparam int AW       = TILE_LOG2 + PIX_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ts_en,
    input  logic                 clr_cmd,
    input  logic [DW-1:0]        clr_value,
    output logic                 clr_ready,
    input  logic                 px_we,
    input  logic [TILE_LOG2-1:0] px_tile,
    input  logic [PIX_LOG2-1:0]  px_off,
    input  logic [DW-1:0]        px_data,
    output logic                 px_ready,
    input  logic                 fill_start,
    input  logic [DW-1:0]        fill_color,
    output logic                 fill_busy,
    output logic                 fill_done,
    input  logic                 rd_en,
    input  logic [TILE_LOG2-1:0] rd_tile,
    input  logic [PIX_LOG2-1:0]  rd_off,
    output logic [DW-1:0]        rd_data,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_rd_addr,
    input  logic [DW-1:0]        mem_rd_data,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata
);
    logic [NT-1:0]        flags;
    logic [DW-1:0]        clear_value;
    logic                 set_all;
    logic                 clr_one;
    logic [TILE_LOG2-1:0] clr_idx;

    tsc_status #(.TILE_LOG2(TILE_LOG2), .DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n),
        .set_all(set_all), .new_value(clr_value),
        .clr_one(clr_one), .clr_idx(clr_idx),
        .flags(flags), .clear_value(clear_value)
    );

    tsc_seq #(.TILE_LOG2(TILE_LOG2), .PIX_LOG2(PIX_LOG2), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .clr_cmd(clr_cmd), .px_we(px_we), .px_tile(px_tile), .px_off(px_off),
        .px_data(px_data), .fill_start(fill_start), .fill_color(fill_color),
        .flags(flags), .clear_value(clear_value),
        .set_all(set_all), .clr_one(clr_one), .clr_idx(clr_idx),
        .clr_ready(clr_ready), .px_ready(px_ready),
        .fill_busy(fill_busy), .fill_done(fill_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    tsc_rdmux #(.TILE_LOG2(TILE_LOG2), .PIX_LOG2(PIX_LOG2), .DW(DW)) u_rdmux (
        .rd_en(rd_en), .rd_tile(rd_tile), .rd_off(rd_off), .ts_en(ts_en),
        .flags(flags), .clear_value(clear_value), .mem_rd_data(mem_rd_data),
        .rd_data(rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr)
    );
endmodule

// File: tb/sim_tile_clear_tracker.sv
module sim_tile_clear_tracker;
    localparam int TL = 3;
    localparam int PL = 2;
    localparam int DW = 16;
    localparam int AW = TL + PL;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ts_en = 1'b0;
    logic clr_cmd = 1'b0;
    logic [DW-1:0] clr_value = '0;
    logic clr_ready;
    logic px_we = 1'b0;
    logic [TL-1:0] px_tile = '0;
    logic [PL-1:0] px_off = '0;
    logic [DW-1:0] px_data = '0;
    logic px_ready;
    logic fill_start = 1'b0;
    logic [DW-1:0] fill_color = '0;
    logic fill_busy, fill_done;
    logic rd_en = 1'b0;
    logic [TL-1:0] rd_tile = '0;
    logic [PL-1:0] rd_off = '0;
    logic [DW-1:0] rd_data;
    logic mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] mem [NW];
    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    int prev_fill_addr = -1;
    bit fill_order_bad = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tile_clear_tracker #(.TILE_LOG2(TL), .PIX_LOG2(PL), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ts_en(ts_en),
        .clr_cmd(clr_cmd), .clr_value(clr_value), .clr_ready(clr_ready),
        .px_we(px_we), .px_tile(px_tile), .px_off(px_off), .px_data(px_data),
        .px_ready(px_ready), .fill_start(fill_start), .fill_color(fill_color),
        .fill_busy(fill_busy), .fill_done(fill_done),
        .rd_en(rd_en), .rd_tile(rd_tile), .rd_off(rd_off), .rd_data(rd_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign mem_rd_data = mem[mem_rd_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
            if (fill_busy) begin
                if (int'(mem_addr) <= prev_fill_addr) fill_order_bad <= 1'b1;
                prev_fill_addr <= int'(mem_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_read(input int t, input int o, input bit ts,
                           input int exp_d, input bit exp_acc, input string req);
        rd_en = 1'b1; rd_tile = TL'(t); rd_off = PL'(o); ts_en = ts;
        #1;
        chk(rd_data == DW'(exp_d), req, int'(rd_data), exp_d);
        chk(mem_rd_en == exp_acc, req, int'(mem_rd_en), int'(exp_acc));
        rd_en = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        chk(clr_ready == 1'b1, "R1 clr_ready", int'(clr_ready), 1);
        chk(fill_busy == 1'b0 && fill_done == 1'b0, "R1 fill idle",
            int'({fill_busy, fill_done}), 0);
        do_read(0, 0, 1'b1, 16'hA000, 1'b1, "R1 no flag after reset");
    endtask

    // R2 R3 R9
    task automatic t_clear();
        clr_cmd = 1'b1; clr_value = 16'h1234;
        px_we = 1'b1; px_tile = 3'd1; px_off = 2'd0; px_data = 16'hDEAD;
        #1;
        chk(px_ready == 1'b0, "R9 clear beats write", int'(px_ready), 0);
        chk(mem_we == 1'b0, "R9 no write with clear", int'(mem_we), 0);
        tick();
        clr_cmd = 1'b0; px_we = 1'b0;
        do_read(3, 2, 1'b1, 16'h1234, 1'b0, "R3 flagged read");
        do_read(1, 0, 1'b1, 16'h1234, 1'b0, "R2 tile1 flagged");
        do_read(3, 2, 1'b0, 16'hA00E, 1'b1, "R3 ts_en off");
    endtask

    // R5
    task automatic t_write_flagged(input int t, input int o, input int d);
        int start, cyc;
        px_we = 1'b1; px_tile = TL'(t); px_off = PL'(o); px_data = DW'(d);
        #1;
        chk(px_ready && mem_we && mem_addr == AW'(t * 4 + o), "R5 write accepted",
            int'(mem_addr), t * 4 + o);
        start = wr_count;
        tick();
        px_we = 1'b0;
        #1;
        chk(px_ready == 1'b0, "R5 busy while expanding", int'(px_ready), 0);
        cyc = 0;
        while (!clr_ready && cyc < 20) begin
            tick();
            cyc++;
        end
        chk(cyc == 4, "R5 expansion cycles", cyc, 4);
        chk(wr_count - start == 4, "R5 writes per tile", wr_count - start, 4);
    endtask

    // R4
    task automatic t_write_plain(input int t, input int o, input int d);
        int start;
        start = wr_count;
        px_we = 1'b1; px_tile = TL'(t); px_off = PL'(o); px_data = DW'(d);
        tick();
        px_we = 1'b0;
        #1;
        chk(px_ready == 1'b1, "R4 ready after plain write", int'(px_ready), 1);
        tick();
        chk(wr_count - start == 1, "R4 one write", wr_count - start, 1);
    endtask

    // R6 R7 R8 R9
    task automatic t_fill(input int color, input int exp_writes, input bit poke_clear);
        int start, cyc, dones;
        start = wr_count;
        prev_fill_addr = -1;
        fill_order_bad = 1'b0;
        fill_start = 1'b1; fill_color = DW'(color);
        px_we = 1'b1; px_tile = 3'd4; px_off = 2'd0; px_data = 16'h9999;
        #1;
        chk(px_ready == 1'b0 && mem_we == 1'b0, "R9 fill beats write",
            int'({px_ready, mem_we}), 0);
        tick();
        fill_start = 1'b0; px_we = 1'b0;
        #1;
        chk(fill_busy == 1'b1, "R7 busy after start", int'(fill_busy), 1);
        if (poke_clear) begin
            clr_cmd = 1'b1; clr_value = 16'h7777;
            #1;
            chk(clr_ready == 1'b0, "R8 clear refused", int'(clr_ready), 0);
            tick();
            clr_cmd = 1'b0;
        end
        cyc = 0;
        dones = 0;
        while (cyc < 200) begin
            #1;
            if (fill_done) begin
                dones++;
                break;
            end
            tick();
            cyc++;
        end
        chk(dones == 1, "R7 done pulse seen", dones, 1);
        chk(wr_count - start == exp_writes, "R6 fill writes", wr_count - start, exp_writes);
        chk(fill_order_bad == 1'b0, "R6 ascending order", int'(fill_order_bad), 0);
        tick();
        chk(fill_done == 1'b0 && clr_ready == 1'b1, "R7 single pulse then idle",
            int'({fill_done, clr_ready}), 1);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = DW'(16'hA000 + i);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_clear();
        t_write_flagged(2, 1, 16'hBEEF);
        do_read(2, 1, 1'b1, 16'hBEEF, 1'b1, "R5 written pixel");
        do_read(2, 0, 1'b1, 16'h1234, 1'b1, "R5 expanded offset 0");
        do_read(2, 3, 1'b1, 16'h1234, 1'b1, "R5 expanded offset 3");
        t_write_plain(2, 3, 16'hCAFE);
        do_read(2, 3, 1'b1, 16'hCAFE, 1'b1, "R4 plain data");
        t_write_flagged(6, 0, 16'h5555);
        do_read(6, 0, 1'b1, 16'h5555, 1'b1, "R5 offset 0 write");
        do_read(6, 3, 1'b1, 16'h1234, 1'b1, "R5 offset 3 expanded");
        t_fill(16'h00F0, 24, 1'b1);
        do_read(5, 2, 1'b1, 16'h00F0, 1'b1, "R6 untouched tile filled");
        do_read(0, 0, 1'b1, 16'h00F0, 1'b1, "R8 second clear had no effect");
        do_read(2, 1, 1'b1, 16'hBEEF, 1'b1, "R6 touched tile kept");
        do_read(6, 0, 1'b1, 16'h5555, 1'b1, "R6 touched tile kept");
        t_fill(16'h0F0F, 0, 1'b0);
        do_read(7, 3, 1'b1, 16'h00F0, 1'b1, "R6 no flags no writes");
        finished = 1'b1;
        summary();
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule